// File: doc/BRIEF.md
# Transform Engine Configuration Port

This block is the configuration front end of a transform engine. A synchronous, SRAM-like port (chip select, active-low write strobe, address, write data, registered read data) is steered by a two-bit target selector. The port reaches a small register file, the window RAM or the data RAM. The register file holds two control words, a scale word and an averaging coefficient at addresses 0 to 3. The RAMs sit outside this block. It only raises their select lines and their clear strobes.

A pin-select input chooses where the engine's effective control words come from. When it is high they come from external pins. When it is low they come from the register file. The continuous-mode bit of the effective control word 0 changes how the selector is decoded. A clear input zeroes the register file, or sends a one-cycle clear strobe to one of the three memories, on each rising edge of the clear input. Two status inputs, end-of-transform and overflow, are merged into control word 0 when it is read back.

Top module: `xcfg_port`

## Requirements
- R1: After reset, all four registers read as zero (except status bits 13/12 of word 0), `rdata` is 0, and `win_clr`, `in_clr` and `out_clr` are 0.
- R2: With continuous mode off (effective control word 0 bit 0 = 0), `clr` low and `cs_n` low, selector values map as follows: 00 raises `reg_sel`, 01 raises `win_sel`, 10 raises `dat_sel`, and 11 raises both `win_sel` and `dat_sel`. With `cs_n` high or `clr` high, no select is raised.
- R3: With continuous mode on, selector 10 raises no select and selector 11 raises `win_sel` only. Selectors 00 and 01 behave as in R2.
- R4: A register read (`reg_sel` with `we_n` high) returns the data on `rdata` one cycle after the address is presented. In every other cycle, `rdata` is 0.
- R5: Control word 0 (address 0) stores bits 11:0 only. On read, bit 13 shows `sts_eot`, bit 12 shows `sts_ovf`, and bits 15:14 read 0. Writes to bits 15:12 are ignored.
- R6: Control word 1 (address 1) stores only bits 9:8, 5:4 and 1:0 (mask 0x0333). The scale word (address 2) and the coefficient (address 3) store all 16 bits.
- R7: Addresses 4 and above read as 0, and writes to them change no register.
- R8: On a clock where `clr` is high and was low on the previous clock, selector 00 zeroes all registers. Selectors 01, 10 and 11 assert `win_clr`, `in_clr` or `out_clr` respectively, for exactly one cycle on the following clock. Holding `clr` high gives no further effect.
- R9: With `pin_sel` high, `eff_cw0 = pin_cw0 & 0x0FFF` and `eff_cw1 = pin_cw1 & 0x0333`. With `pin_sel` low, they equal the stored register values.
- R10: `rd_drive` is high exactly while `cs_n` is low and `we_n` is high.
- R11: A write with `cs_n` high changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_sel | input | 2 | Target selector |
| clr | input | 1 | Clear request, acts on its rising edge |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 11 | Register / RAM address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| rd_drive | output | 1 | Data port output enable |
| sts_eot | input | 1 | End-of-transform status |
| sts_ovf | input | 1 | Overflow status |
| pin_sel | input | 1 | 1 = settings from pins |
| pin_cw0 | input | 16 | Pin value of control word 0 |
| pin_cw1 | input | 16 | Pin value of control word 1 |
| eff_cw0 | output | 16 | Effective control word 0 |
| eff_cw1 | output | 16 | Effective control word 1 |
| scale_val | output | 16 | Scale register |
| alpha_val | output | 16 | Averaging coefficient |
| reg_sel | output | 1 | Register file selected |
| win_sel | output | 1 | Window RAM selected |
| dat_sel | output | 1 | Data RAM selected |
| win_clr | output | 1 | Window RAM clear strobe |
| in_clr | output | 1 | Input RAM clear strobe |
| out_clr | output | 1 | Output RAM clear strobe |

## Verification
A wrongly stored register bit shows on `eff_cw0`/`eff_cw1` in the cycle after the write. It also shows on `rdata` one cycle after the next read of that address. A corrupted continuous-mode bit shows at once as a wrong select for selectors 10 and 11. A broken clear edge detector shows as a missing strobe or a repeated strobe on the cycle after `clr` rises, or on the cycles while it is held high. Every comparison against the bench model runs on every clock, so any of these shows up within one or two cycles of the stimulus that exposes it.

// File: rtl/xcfg_pkg.sv
// Shared constants for the configuration port.
// Assumes a 16-bit register layout; masks below encode which bits are stored.
package xcfg_pkg;
    localparam logic [15:0] CW0_WMASK = 16'h0FFF;
    localparam logic [15:0] CW1_WMASK = 16'h0333;
    localparam int          EOT_BIT   = 13;
    localparam int          OVF_BIT   = 12;
    localparam int          CONT_BIT  = 0;

    typedef enum logic [1:0] {
        TGT_REG  = 2'b00,
        TGT_WIN  = 2'b01,
        TGT_DAT  = 2'b10,
        TGT_BOTH = 2'b11
    } tgt_e;

    // Writable-bit mask for register index i.
    function automatic logic [15:0] wmask(input int i);
        case (i)
            0:       wmask = CW0_WMASK;
            1:       wmask = CW1_WMASK;
            default: wmask = 16'hFFFF;
        endcase
    endfunction
endpackage

// File: rtl/xcfg_decode.sv
// Target decode and clear sequencing.
// Assumes clr is synchronous to clk; only its rising edge has an effect.
module xcfg_decode
    import xcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] acc_sel,
    input  logic       clr,
    input  logic       cs_n,
    input  logic       cont,
    output logic       reg_sel,
    output logic       win_sel,
    output logic       dat_sel,
    output logic       clr_regs,
    output logic       win_clr,
    output logic       in_clr,
    output logic       out_clr
);
    logic clr_q;
    logic clr_rise;
    logic access;

    assign clr_rise = clr && !clr_q;
    assign access   = !cs_n && !clr;

    // Steer the port from selector and continuous-mode bit.
    always_comb begin
        reg_sel = 1'b0;
        win_sel = 1'b0;
        dat_sel = 1'b0;
        if (access) begin
            case (tgt_e'(acc_sel))
                TGT_REG:  reg_sel = 1'b1;
                TGT_WIN:  win_sel = 1'b1;
                TGT_DAT:  dat_sel = !cont;
                TGT_BOTH: begin
                    win_sel = 1'b1;
                    dat_sel = !cont;
                end
                default:  reg_sel = 1'b0;
            endcase
        end
    end

    assign clr_regs = clr_rise && (acc_sel == TGT_REG);

    // Remember clr and issue one-cycle memory clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_q   <= 1'b0;
            win_clr <= 1'b0;
            in_clr  <= 1'b0;
            out_clr <= 1'b0;
        end else begin
            clr_q   <= clr;
            win_clr <= clr_rise && (acc_sel == 2'b01);
            in_clr  <= clr_rise && (acc_sel == 2'b10);
            out_clr <= clr_rise && (acc_sel == 2'b11);
        end
    end
endmodule

// File: rtl/xcfg_regfile.sv
// Register file with masked writes and one-cycle registered read-back.
// Assumes NREG is a power of two and at least 4; indices 0/1 are control words.
module xcfg_regfile
    import xcfg_pkg::*;
#(
    parameter int AW   = 11,
    parameter int NREG = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    input  logic          clr_regs,
    input  logic          sts_eot,
    input  logic          sts_ovf,
    output logic [15:0]   cw0,
    output logic [15:0]   cw1,
    output logic [15:0]   scale,
    output logic [15:0]   alpha,
    output logic [15:0]   rdata
);
    localparam int IW = $clog2(NREG);

    logic [15:0]   regs_q [NREG];
    logic          hit;
    logic [IW-1:0] idx;
    logic [15:0]   rd_val;

    assign hit = (addr[AW-1:IW] == '0);
    assign idx = addr[IW-1:0];

    // One storage register per index, keeping only its writable bits.
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n || clr_regs) begin
                regs_q[i] <= '0;
            end else if (acc_en && !we_n && hit && idx == IW'(i)) begin
                regs_q[i] <= wdata & wmask(i);
            end
        end
    end

    // Read mux with status bits merged into word 0.
    always_comb begin
        rd_val = '0;
        if (hit) begin
            rd_val = regs_q[idx];
            if (idx == '0) begin
                rd_val[EOT_BIT] = sts_eot;
                rd_val[OVF_BIT] = sts_ovf;
            end
        end
    end

    // Capture read data one cycle after a register read.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= (acc_en && we_n) ? rd_val : '0;
    end

    assign cw0   = regs_q[0];
    assign cw1   = regs_q[1];
    assign scale = regs_q[2];
    assign alpha = regs_q[3];
endmodule

// File: rtl/xcfg_select.sv
// Pin-versus-register source select for the effective control words.
// Assumes register values already hold only their writable bits.
module xcfg_select
    import xcfg_pkg::*;
(
    input  logic        pin_sel,
    input  logic [15:0] pin_cw0,
    input  logic [15:0] pin_cw1,
    input  logic [15:0] reg_cw0,
    input  logic [15:0] reg_cw1,
    output logic [15:0] eff_cw0,
    output logic [15:0] eff_cw1
);
    // Pick the source and drop bits that are not settings.
    always_comb begin
        if (pin_sel) begin
            eff_cw0 = pin_cw0 & CW0_WMASK;
            eff_cw1 = pin_cw1 & CW1_WMASK;
        end else begin
            eff_cw0 = reg_cw0;
            eff_cw1 = reg_cw1;
        end
    end
endmodule

// File: rtl/xcfg_port.sv
// Top of the configuration port: decode, register file and source select.
// Assumes all inputs are synchronous to clk; RAMs live outside this block.
module xcfg_port
    import xcfg_pkg::*;
#(
    parameter int AW   = 11,
    parameter int NREG = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    acc_sel,
    input  logic          clr,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    output logic [15:0]   rdata,
    output logic          rd_drive,
    input  logic          sts_eot,
    input  logic          sts_ovf,
    input  logic          pin_sel,
    input  logic [15:0]   pin_cw0,
    input  logic [15:0]   pin_cw1,
    output logic [15:0]   eff_cw0,
    output logic [15:0]   eff_cw1,
    output logic [15:0]   scale_val,
    output logic [15:0]   alpha_val,
    output logic          reg_sel,
    output logic          win_sel,
    output logic          dat_sel,
    output logic          win_clr,
    output logic          in_clr,
    output logic          out_clr
);
    logic        clr_regs;
    logic [15:0] cw0_q;
    logic [15:0] cw1_q;

    // Data port drive enable for reads.
    assign rd_drive = !cs_n && we_n;

    xcfg_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_sel  (acc_sel),
        .clr      (clr),
        .cs_n     (cs_n),
        .cont     (eff_cw0[CONT_BIT]),
        .reg_sel  (reg_sel),
        .win_sel  (win_sel),
        .dat_sel  (dat_sel),
        .clr_regs (clr_regs),
        .win_clr  (win_clr),
        .in_clr   (in_clr),
        .out_clr  (out_clr)
    );

    xcfg_regfile #(.AW(AW), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (reg_sel),
        .we_n     (we_n),
        .addr     (addr),
        .wdata    (wdata),
        .clr_regs (clr_regs),
        .sts_eot  (sts_eot),
        .sts_ovf  (sts_ovf),
        .cw0      (cw0_q),
        .cw1      (cw1_q),
        .scale    (scale_val),
        .alpha    (alpha_val),
        .rdata    (rdata)
    );

    xcfg_select u_sel (
        .pin_sel (pin_sel),
        .pin_cw0 (pin_cw0),
        .pin_cw1 (pin_cw1),
        .reg_cw0 (cw0_q),
        .reg_cw1 (cw1_q),
        .eff_cw0 (eff_cw0),
        .eff_cw1 (eff_cw1)
    );
endmodule

// File: rtl/xcfg_port_chk.sv
// Property checker for the configuration port, attached by bind.
module xcfg_port_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    acc_sel,
    input logic          clr,
    input logic          cs_n,
    input logic          we_n,
    input logic [AW-1:0] addr,
    input logic [15:0]   rdata,
    input logic [15:0]   eff_cw0,
    input logic [15:0]   eff_cw1,
    input logic          reg_sel,
    input logic          win_sel,
    input logic          dat_sel,
    input logic          win_clr,
    input logic          in_clr,
    input logic          out_clr
);
    // R8
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({win_clr, in_clr, out_clr}));

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_clr || in_clr || out_clr) |=> !(win_clr || in_clr || out_clr));

    // R3
    cont_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_cw0[0] && acc_sel[1]) |-> !dat_sel && !reg_sel);

    // R2
    clr_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !(reg_sel || win_sel || dat_sel));

    // R4
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_sel && we_n) |-> rdata == 16'h0000);

    // R6
    cw1_read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_sel && we_n && addr == AW'(1)) |-> (rdata & 16'hFCCC) == 16'h0000);

    // R5
    eff_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eff_cw0[15:12] == 4'h0 && (eff_cw1 & 16'hFCCC) == 16'h0000);
endmodule

bind xcfg_port xcfg_port_chk #(.AW(AW)) chk_i (.*);

// File: tb/xcfg_port_tb_top.sv
`timescale 1ns/1ps
module xcfg_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  acc_sel = 2'b00;
    logic        clr = 1'b0;
    logic        cs_n = 1'b1;
    logic        we_n = 1'b1;
    logic [10:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rd_drive;
    logic        sts_eot = 1'b0;
    logic        sts_ovf = 1'b0;
    logic        pin_sel = 1'b0;
    logic [15:0] pin_cw0 = '0;
    logic [15:0] pin_cw1 = '0;
    logic [15:0] eff_cw0, eff_cw1, scale_val, alpha_val;
    logic        reg_sel, win_sel, dat_sel, win_clr, in_clr, out_clr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = !clk;

    xcfg_port dut_i (.*);

    // Reference model state
    logic [15:0] m_reg [4];
    logic [15:0] m_rdata;
    logic        m_wclr, m_iclr, m_oclr, m_clrq;
    logic        m_rise, m_racc;
    string       m_rlbl = "R4";

    function automatic logic [15:0] ref_mask(input int i);
        if (i == 0) return 16'h0FFF;
        if (i == 1) return 16'h0333;
        return 16'hFFFF;
    endfunction

    function automatic logic [15:0] ref_read(input int a);
        logic [15:0] v;
        if (a >= 4) return 16'h0;
        v = m_reg[a];
        if (a == 0) v = v | (16'(sts_eot) << 13) | (16'(sts_ovf) << 12);
        return v;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Model update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_reg[i] = '0;
            m_rdata = '0; m_wclr = 0; m_iclr = 0; m_oclr = 0; m_clrq = 0;
        end else begin
            m_rise = clr && !m_clrq;
            m_clrq = clr;
            m_wclr = m_rise && acc_sel == 2'd1;
            m_iclr = m_rise && acc_sel == 2'd2;
            m_oclr = m_rise && acc_sel == 2'd3;
            m_racc = !cs_n && !clr && acc_sel == 2'd0;
            if (m_racc && we_n) begin
                m_rdata = ref_read(int'(addr));
                m_rlbl  = (addr >= 4) ? "R7" : (addr == 0) ? "R5" : "R6";
            end else begin
                m_rdata = '0;
                m_rlbl  = "R4";
            end
            if (m_racc && !we_n && addr < 4) m_reg[addr] = wdata & ref_mask(int'(addr));
            if (m_rise && acc_sel == 2'd0)
                for (int i = 0; i < 4; i++) m_reg[i] = '0;
        end
    end

    // Compare every output against the model on each falling edge
    always @(negedge clk) begin
        logic acc, cont;
        logic [15:0] e0, e1;
        if (rst_n && !done) begin
            acc  = !cs_n && !clr;
            cont = pin_sel ? pin_cw0[0] : m_reg[0][0];
            e0   = pin_sel ? (pin_cw0 & 16'h0FFF) : m_reg[0];
            e1   = pin_sel ? (pin_cw1 & 16'h0333) : m_reg[1];
            check(m_rlbl, rdata, m_rdata);
            check(cont ? "R3 reg_sel" : "R2 reg_sel", 16'(reg_sel), 16'(acc && acc_sel == 0));
            check(cont ? "R3 win_sel" : "R2 win_sel", 16'(win_sel), 16'(acc && acc_sel[0]));
            check(cont ? "R3 dat_sel" : "R2 dat_sel", 16'(dat_sel), 16'(acc && acc_sel[1] && !cont));
            check("R8 strobes", {13'd0, win_clr, in_clr, out_clr}, {13'd0, m_wclr, m_iclr, m_oclr});
            check("R9 eff_cw0", eff_cw0, e0);
            check("R9 eff_cw1", eff_cw1, e1);
            check("R6 scale", scale_val, m_reg[2]);
            check("R6 alpha", alpha_val, m_reg[3]);
            check("R10 rd_drive", 16'(rd_drive), 16'(!cs_n && we_n));
        end
    end

    task automatic idle();
        cs_n = 1; we_n = 1; clr = 0; acc_sel = 0;
    endtask

    task automatic wr(input logic [10:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        cs_n = 0; we_n = 0; acc_sel = 0; addr = a; wdata = d;
        @(negedge clk); #1; idle();
    endtask

    task automatic rd_expect(input logic [10:0] a, input logic [15:0] exp, input string req);
        @(negedge clk); #1;
        cs_n = 0; we_n = 1; acc_sel = 0; addr = a;
        @(negedge clk);
        check(req, rdata, exp);
        #1; idle();
    endtask

    task automatic sweep_sel();
        for (int s = 0; s < 4; s++) begin
            @(negedge clk); #1;
            cs_n = 0; we_n = 1; acc_sel = 2'(s); addr = 11'h10;
        end
        @(negedge clk); #1; idle();
    endtask

    task automatic pulse_clr(input logic [1:0] s, input logic exp_w, exp_i, exp_o);
        @(negedge clk); #1;
        clr = 1; acc_sel = s; cs_n = 0; we_n = 0; addr = 11'd2; wdata = 16'h1234;
        @(negedge clk);
        check("R8 first strobe", {13'd0, win_clr, in_clr, out_clr}, {13'd0, exp_w, exp_i, exp_o});
        @(negedge clk);
        check("R8 held clear", {13'd0, win_clr, in_clr, out_clr}, 16'd0);
        @(negedge clk);
        #1; idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1; rst_n = 1;
        @(negedge clk);
        check("R1 rdata", rdata, 16'h0);
        check("R1 strobes", {13'd0, win_clr, in_clr, out_clr}, 16'h0);
        rd_expect(11'd0, 16'h0, "R1 cw0");
        rd_expect(11'd1, 16'h0, "R1 cw1");
        rd_expect(11'd2, 16'h0, "R1 scale");
        rd_expect(11'd3, 16'h0, "R1 alpha");

        // Masked writes and status merge
        wr(11'd0, 16'hFFFE); wr(11'd1, 16'hFFFF); wr(11'd2, 16'hA5C3); wr(11'd3, 16'h7FFF);
        sts_eot = 1; sts_ovf = 0;
        rd_expect(11'd0, 16'h2FFE, "R5 cw0 eot");
        sts_eot = 0; sts_ovf = 1;
        rd_expect(11'd0, 16'h1FFE, "R5 cw0 ovf");
        sts_ovf = 0;
        rd_expect(11'd1, 16'h0333, "R6 cw1");
        rd_expect(11'd2, 16'hA5C3, "R6 scale");
        rd_expect(11'd3, 16'h7FFF, "R6 alpha");

        // Out-of-range addresses
        wr(11'd4, 16'hBEEF); wr(11'h7FE, 16'h1111);
        rd_expect(11'd4, 16'h0, "R7 read 4");
        rd_expect(11'd2, 16'hA5C3, "R7 scale kept");
        rd_expect(11'd0, 16'h0FFE, "R7 cw0 kept");

        // Write with chip select inactive
        @(negedge clk); #1; cs_n = 1; we_n = 0; addr = 11'd3; wdata = 16'h0000;
        @(negedge clk); #1; idle();
        rd_expect(11'd3, 16'h7FFF, "R11 alpha kept");

        // Steering, continuous off then on
        sweep_sel();
        wr(11'd0, 16'h0001);
        sweep_sel();
        pin_sel = 1; pin_cw0 = 16'hF000; pin_cw1 = 16'hFFFF;
        sweep_sel();
        pin_cw0 = 16'hFFFF;
        sweep_sel();
        pin_sel = 0;

        // Clears
        pulse_clr(2'd1, 1, 0, 0);
        pulse_clr(2'd2, 0, 1, 0);
        pulse_clr(2'd3, 0, 0, 1);
        rd_expect(11'd2, 16'hA5C3, "R8 scale survives RAM clear");
        pulse_clr(2'd0, 0, 0, 0);
        rd_expect(11'd2, 16'h0, "R8 scale cleared");
        rd_expect(11'd0, 16'h0, "R8 cw0 cleared");

        // Mixed stimulus compared against the model each clock
        for (int n = 0; n < 400; n++) begin
            @(negedge clk); #1;
            acc_sel = 2'($urandom_range(0, 3));
            clr     = ($urandom_range(0, 15) == 0);
            cs_n    = ($urandom_range(0, 3) == 0);
            we_n    = $urandom_range(0, 1);
            addr    = ($urandom_range(0, 7) == 0) ? 11'($urandom) : 11'($urandom_range(0, 5));
            wdata   = 16'($urandom);
            sts_eot = $urandom_range(0, 1);
            sts_ovf = $urandom_range(0, 1);
            pin_sel = ($urandom_range(0, 3) == 0);
            pin_cw0 = 16'($urandom);
            pin_cw1 = 16'($urandom);
        end
        @(negedge clk); #1; idle(); pin_sel = 0;
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule